// File: doc/BRIEF.md
# Multi-Source Interrupt Flag Controller

This block gathers interrupt causes from a group of processing engines and turns them into a small set of host interrupt lines. Each engine contributes a receive-not-empty level and a transmit-not-full level taken directly from its FIFO status. The block also holds a bank of internal event flags. The engines set these flags with single-cycle pulses, and the host can set or clear them through a register port. Only the lower part of the flag bank is visible in the host interrupt vector. The upper flags exist only for engine-to-engine signalling.

All the sources are merged into one shared raw vector. Every interrupt output has its own enable mask and force mask over that vector. Its status is the raw vector ORed with its force mask and then ANDed with its enable mask, and the output line is high when any status bit is set. Forcing an output bit changes only what that output reports. The event flags seen by the engines do not change.

The host reaches every register through one word-addressed port. Writes take effect at the clock edge. Reads are combinational on the address.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all event flags, all enable masks and all force masks are zero, and every interrupt output is low.
- R2: The raw vector, read at word address 2, carries receive-not-empty of engines 0..3 in bits 3:0, transmit-not-full of engines 0..3 in bits 7:4 and event flags 0..3 in bits 11:8, with all higher bits zero. The FIFO bits follow their inputs as levels, with no latching.
- R3: A one on bit i of `flag_set_i` sets event flag i at the next clock edge, and the flag stays set until the host clears it.
- R4: Writing to word address 0 clears every event flag whose write-data bit is one and leaves the others unchanged. Reading word address 0 returns all eight flags in bits 7:0.
- R5: Writing to word address 1 sets every event flag whose write-data bit is one. Flags 4..7 appear on `flag_o` and at address 0 but never in the raw vector.
- R6: When an engine sets a flag in the same cycle that the host clears it, the flag ends up set.
- R7: Output k has a read/write enable mask at word address 4+4k and a read/write force mask at 5+4k, each 12 bits wide. Its read-only status at 6+4k equals (raw OR force) AND enable.
- R8: Writing an output's force mask does not change the event flags or the raw vector.
- R9: `irq_o[k]` is high exactly when the status of output k is non-zero, and the enable and force masks of one output do not affect the other output.
- R10: Writes to read-only or unmapped addresses change no state, and reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_nempty_i | input | N_ENG | Receive FIFO not-empty level per engine |
| tx_nfull_i | input | N_ENG | Transmit FIFO not-full level per engine |
| flag_set_i | input | N_FLAG | Engine-side event flag set pulses |
| flag_o | output | N_FLAG | Current event flags as seen by the engines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational on the address |
| irq_o | output | N_OUT | Interrupt output lines |

## Verification
The bench uses the default parameters: four engines, eight flags of which four are visible, two outputs and a 4-bit address. With these values every bit of the 12-bit raw vector can be driven, the hidden flags 4..7 can be shown to stay out of the vector, and the two outputs can be given different masks at the same time to show that they are independent. The set-versus-clear collision and writes to the raw and unmapped addresses are driven as directed cases.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADDR_FLAGS    = 0;
  localparam int unsigned ADDR_FLAG_SET = 1;
  localparam int unsigned ADDR_RAW      = 2;
  localparam int unsigned OUT_BASE      = 4;
  localparam int unsigned OUT_STRIDE    = 4;

  typedef enum logic [1:0] {
    OFF_EN   = 2'd0,
    OFF_FRC  = 2'd1,
    OFF_STAT = 2'd2
  } out_off_e;

  function automatic int unsigned out_addr(int unsigned k, out_off_e off);
    return OUT_BASE + k * OUT_STRIDE + int'(off);
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N_FLAG = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_FLAG-1:0] set_i,
  input  logic [N_FLAG-1:0] clr_i,
  input  logic [N_FLAG-1:0] frc_i,
  output logic [N_FLAG-1:0] flags_o
);
  logic [N_FLAG-1:0] flags_q;

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    // set from either side wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    flags_q[i] <= 1'b0;
      else if (set_i[i] || frc_i[i])  flags_q[i] <= 1'b1;
      else if (clr_i[i])              flags_q[i] <= 1'b0;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl #(
  parameter int unsigned RAW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic             frc_we_i,
  input  logic [RAW_W-1:0] wdata_i,
  input  logic [RAW_W-1:0] raw_i,
  output logic [RAW_W-1:0] en_o,
  output logic [RAW_W-1:0] frc_o,
  output logic [RAW_W-1:0] stat_o,
  output logic             irq_o
);
  logic [RAW_W-1:0] en_q, frc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      frc_q <= '0;
    end else begin
      if (en_we_i)  en_q  <= wdata_i;
      if (frc_we_i) frc_q <= wdata_i;
    end
  end

  assign en_o   = en_q;
  assign frc_o  = frc_q;
  assign stat_o = (raw_i | frc_q) & en_q;
  assign irq_o  = |stat_o;
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_pkg::*;
#(
  parameter int unsigned N_FLAG = 8,
  parameter int unsigned N_OUT  = 2,
  parameter int unsigned RAW_W  = 12,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [N_FLAG-1:0]           flags_i,
  input  logic [RAW_W-1:0]            raw_i,
  input  logic [N_OUT-1:0][RAW_W-1:0] en_i,
  input  logic [N_OUT-1:0][RAW_W-1:0] frc_i,
  input  logic [N_OUT-1:0][RAW_W-1:0] stat_i,
  output logic [N_FLAG-1:0]           flag_clr_o,
  output logic [N_FLAG-1:0]           flag_frc_o,
  output logic [N_OUT-1:0]            en_we_o,
  output logic [N_OUT-1:0]            frc_we_o,
  output logic [RAW_W-1:0]            wdata_o,
  output logic [DATA_W-1:0]           rdata_o
);
  logic wr, rd;
  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign wdata_o = wdata_i[RAW_W-1:0];

  always_comb begin
    flag_clr_o = '0;
    flag_frc_o = '0;
    en_we_o    = '0;
    frc_we_o   = '0;
    if (wr) begin
      if (addr_i == ADDR_W'(ADDR_FLAGS))    flag_clr_o = wdata_i[N_FLAG-1:0];
      if (addr_i == ADDR_W'(ADDR_FLAG_SET)) flag_frc_o = wdata_i[N_FLAG-1:0];
      for (int k = 0; k < N_OUT; k++) begin
        if (addr_i == ADDR_W'(out_addr(k, OFF_EN)))  en_we_o[k]  = 1'b1;
        if (addr_i == ADDR_W'(out_addr(k, OFF_FRC))) frc_we_o[k] = 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (addr_i == ADDR_W'(ADDR_FLAGS)) rdata_o = DATA_W'(flags_i);
      if (addr_i == ADDR_W'(ADDR_RAW))   rdata_o = DATA_W'(raw_i);
      for (int k = 0; k < N_OUT; k++) begin
        if (addr_i == ADDR_W'(out_addr(k, OFF_EN)))   rdata_o = DATA_W'(en_i[k]);
        if (addr_i == ADDR_W'(out_addr(k, OFF_FRC)))  rdata_o = DATA_W'(frc_i[k]);
        if (addr_i == ADDR_W'(out_addr(k, OFF_STAT))) rdata_o = DATA_W'(stat_i[k]);
      end
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int unsigned N_ENG  = 4,
  parameter int unsigned N_FLAG = 8,
  parameter int unsigned N_VIS  = 4,
  parameter int unsigned N_OUT  = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ENG-1:0]  rx_nempty_i,
  input  logic [N_ENG-1:0]  tx_nfull_i,
  input  logic [N_FLAG-1:0] flag_set_i,
  output logic [N_FLAG-1:0] flag_o,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_OUT-1:0]  irq_o
);
  localparam int unsigned RAW_W = 2 * N_ENG + N_VIS;

  logic [N_FLAG-1:0]           flags, flag_clr, flag_frc;
  logic [RAW_W-1:0]            raw, wdata_raw;
  logic [N_OUT-1:0][RAW_W-1:0] en_q, frc_q, stat;
  logic [N_OUT-1:0]            en_we, frc_we;

  assign raw    = {flags[N_VIS-1:0], tx_nfull_i, rx_nempty_i};
  assign flag_o = flags;

  irq_flag_bank #(.N_FLAG(N_FLAG)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set_i),
    .clr_i   (flag_clr),
    .frc_i   (flag_frc),
    .flags_o (flags)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    irq_out_ctrl #(.RAW_W(RAW_W)) u_out (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_we_i  (en_we[k]),
      .frc_we_i (frc_we[k]),
      .wdata_i  (wdata_raw),
      .raw_i    (raw),
      .en_o     (en_q[k]),
      .frc_o    (frc_q[k]),
      .stat_o   (stat[k]),
      .irq_o    (irq_o[k])
    );
  end

  irq_regif #(
    .N_FLAG(N_FLAG), .N_OUT(N_OUT), .RAW_W(RAW_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regif (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .flags_i    (flags),
    .raw_i      (raw),
    .en_i       (en_q),
    .frc_i      (frc_q),
    .stat_i     (stat),
    .flag_clr_o (flag_clr),
    .flag_frc_o (flag_frc),
    .en_we_o    (en_we),
    .frc_we_o   (frc_we),
    .wdata_o    (wdata_raw),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int unsigned N_ENG  = 4,
  parameter int unsigned N_FLAG = 8,
  parameter int unsigned N_OUT  = 2,
  parameter int unsigned RAW_W  = 12,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_ENG-1:0]            rx_nempty_i,
  input logic [N_FLAG-1:0]           flag_set_i,
  input logic [N_FLAG-1:0]           flag_o,
  input logic                        req_i,
  input logic                        we_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [DATA_W-1:0]           wdata_i,
  input logic [DATA_W-1:0]           rdata_o,
  input logic [N_OUT-1:0]            irq_o,
  input logic [N_OUT-1:0][RAW_W-1:0] en_q
);
  logic [N_FLAG-1:0] host_clr, host_set;
  assign host_clr = (req_i && we_i && addr_i == ADDR_W'(0)) ? wdata_i[N_FLAG-1:0] : '0;
  assign host_set = (req_i && we_i && addr_i == ADDR_W'(1)) ? wdata_i[N_FLAG-1:0] : '0;

  // R3, R6: an engine set always lands, even against a clear
  a_r3_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_set_i) |=> ((flag_o & $past(flag_set_i)) == $past(flag_set_i)));

  a_r4_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|host_clr) |=> ((flag_o & $past(host_clr & ~flag_set_i & ~host_set)) == '0));

  a_r5_host_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|host_set) |=> ((flag_o & $past(host_set)) == $past(host_set)));

  a_r2_raw_rx_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(2)) |-> (rdata_o[N_ENG-1:0] == rx_nempty_i));

  for (genvar k = 0; k < N_OUT; k++) begin : g_chk
    a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[k] == '0) |-> !irq_o[k]);
  end
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
  .N_ENG(N_ENG), .N_FLAG(N_FLAG), .N_OUT(N_OUT), .RAW_W(RAW_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_nempty_i (rx_nempty_i),
  .flag_set_i  (flag_set_i),
  .flag_o      (flag_o),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .en_q        (en_q)
);

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  rx_nempty_i = '0, tx_nfull_i = '0;
  logic [7:0]  flag_set_i = '0;
  logic [7:0]  flag_o;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [1:0]  irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  irq_flag_ctrl u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0; wdata_i = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    req_i = 0;
  endtask

  task automatic pulse(logic [7:0] v);
    @(negedge clk_i);
    flag_set_i = v;
    @(negedge clk_i);
    flag_set_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 flags", 32'(flag_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    rd(4, d);  chk("R1 en0", d, 0);
    rd(9, d);  chk("R1 frc1", d, 0);
  endtask

  task automatic t_raw();
    logic [31:0] d;
    rx_nempty_i = 4'b1010; tx_nfull_i = 4'b0101;
    rd(2, d); chk("R2 raw layout", d, 32'h05A);
    rx_nempty_i = 4'b0001; tx_nfull_i = 4'b1000;
    rd(2, d); chk("R2 raw level follows", d, 32'h081);
    rx_nempty_i = '0; tx_nfull_i = '0;
  endtask

  task automatic t_engine_set();
    logic [31:0] d;
    pulse(8'h21);
    chk("R3 flags set", 32'(flag_o), 32'h21);
    repeat (3) @(negedge clk_i);
    chk("R3 flags hold", 32'(flag_o), 32'h21);
    rd(2, d); chk("R5 hidden flag 5 not in raw", d, 32'h100);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(0, 32'h01);
    rd(0, d); chk("R4 w1c one bit", d, 32'h20);
    wr(0, 32'h00);
    chk("R4 zero write no effect", 32'(flag_o), 32'h20);
  endtask

  task automatic t_force_flag();
    logic [31:0] d;
    wr(1, 32'h8C);
    chk("R5 host set", 32'(flag_o), 32'hAC);
    rd(2, d); chk("R5 raw flags", d, 32'hC00);
    wr(0, 32'hFF);
    chk("R4 clear all", 32'(flag_o), 0);
  endtask

  task automatic t_set_wins();
    @(negedge clk_i);
    flag_set_i = 8'h03;
    req_i = 1; we_i = 1; addr_i = 0; wdata_i = 32'h03;
    @(negedge clk_i);
    flag_set_i = '0; req_i = 0; we_i = 0;
    chk("R6 set wins", 32'(flag_o), 32'h03);
    wr(0, 32'hFF);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    rx_nempty_i = 4'b1010;
    wr(4, 32'h00F);
    wr(8, 32'hF00);
    rd(6, d);  chk("R7 status0", d, 32'h00A);
    chk("R9 irq0 hi irq1 lo", 32'(irq_o), 32'b01);
    pulse(8'h04);
    rd(10, d); chk("R7 status1 flag2", d, 32'h400);
    chk("R9 both irq", 32'(irq_o), 32'b11);
    rd(8, d);  chk("R7 en1 readback", d, 32'hF00);
    rx_nempty_i = '0;
    wr(0, 32'hFF);
    chk("R9 both low", 32'(irq_o), 0);
  endtask

  task automatic t_force_out();
    logic [31:0] d;
    wr(8, 32'hF01);
    wr(9, 32'h001);
    rd(10, d); chk("R8 forced status1", d, 32'h001);
    chk("R9 irq1 via force", 32'(irq_o), 32'b10);
    chk("R8 flags untouched", 32'(flag_o), 0);
    rd(2, d);  chk("R8 raw untouched", d, 0);
    wr(5, 32'h800);
    rd(6, d);  chk("R9 force masked off", d, 0);
    wr(9, 32'h0);
    chk("R9 irq low after unforce", 32'(irq_o), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(2, 32'hFFF);
    wr(3, 32'hFFF);
    wr(6, 32'hFFF);
    wr(15, 32'hFFF);
    chk("R10 flags", 32'(flag_o), 0);
    rd(4, d);  chk("R10 en0 unchanged", d, 32'h00F);
    rd(2, d);  chk("R10 raw", d, 0);
    rd(3, d);  chk("R10 unmapped read", d, 0);
    rd(15, d); chk("R10 unmapped read hi", d, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_raw();
    t_engine_set();
    t_clear();
    t_force_flag();
    t_set_wins();
    t_mask();
    t_force_out();
    t_unmapped();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule